// File: doc/BRIEF.md
# Reloading Overflow Timer

A 32-bit up-counting timer with a small word-wide register bus. Software presets a count and a reload value, picks which interrupt sources are enabled, and starts the counter with auto-reload on or off. The counter advances once on each cycle where the tick-enable input is high and the start bit is set. When it steps past all-ones it takes the reload value and raises an overflow status flag. That flag is cleared by writing a one to it.

A reload value of 0xFFFFFFFF − (N − 1) makes the timer overflow every N ticks, which suits a periodic system tick. A reload value of 0 turns the block into a free-running 32-bit counter whose live value can be read at any time. A level interrupt is raised while an enabled status flag is pending. A parameter chooses between two register address layouts.

Top module: `ovf_timer`

## Requirements
- R1: After reset every register reads 0 and `irq` is low.
- R2: With `LAYOUT`=0 the status, enable, control, counter and reload registers sit at byte offsets 0x28, 0x2C, 0x38, 0x3C and 0x40. With `LAYOUT`=1 they sit at 0x18, 0x1C, 0x24, 0x28 and 0x2C. Any other offset reads 0.
- R3: The counter adds one on each cycle where `tick_en` is high and control bit 0 (start) is 1. Otherwise it holds.
- R4: A write to the counter register loads the written value, and it takes priority over an increment in the same cycle.
- R5: A step from 0xFFFFFFFF loads the reload register value. With control bit 1 (auto-reload) set, a reload value of 0xFFFFFFFF − (N − 1) gives an overflow every N ticks.
- R6: An overflow sets status bit 1. Writing 1 to status bit 1 clears it, and writing 0 leaves it unchanged. An overflow in the same cycle as a clearing write leaves the flag set.
- R7: Without auto-reload, an overflow loads the reload value, sets status bit 1 and clears the start bit, so the counter then holds.
- R8: The enable register keeps bits 2:0 (bit 0 match, bit 1 overflow, bit 2 capture) and the control register keeps bits 1:0. Their other bits read 0. The status register reads 0 except for bit 1.
- R9: `irq` is the OR of each status bit ANDed with its enable bit. It stays high while status bit 1 and enable bit 1 are both 1, and is low when enable bit 1 is 0.
- R10: With a reload value of 0 and a counter preset of R, the counter reads R + k after k enabled ticks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick_en | input | 1 | Count-enable strobe, one tick per high cycle |
| bus_addr | input | ADDR_W | Byte offset of the register accessed |
| bus_wr | input | 1 | Write strobe for `bus_wdata` at `bus_addr` |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq | output | 1 | Level interrupt request |

## Verification
The bench targets the cases that are easy to get wrong:
- An overflow in the same cycle as a write-one-to-clear. A design that lets the clear win would lose that tick's interrupt.
- A counter write while ticking. A design with the wrong priority would read back the written value plus one.
- A one-shot wrap. A design that leaves start set would keep counting past the reload value.
- The exact N-tick period. An off-by-one in the wrap would raise the flag a tick early or late, and the bench checks the flag still clear one tick before the period ends.

Both address layouts are instanced, so a swapped offset shows up as data read back from an unmapped address.

// File: rtl/ovt_pkg.sv
package ovt_pkg;
  localparam int DATA_W   = 32;
  localparam int NREG     = 5;
  localparam int IDX_STAT = 0;
  localparam int IDX_IEN  = 1;
  localparam int IDX_CTRL = 2;
  localparam int IDX_CNT  = 3;
  localparam int IDX_LOAD = 4;
  localparam int IEN_W    = 3;
  localparam int CTRL_W   = 2;
  localparam int OVF_BIT  = 1;
  localparam int START_BIT = 0;
  localparam int AUTO_BIT  = 1;

  // Byte offset of register idx in the selected layout
  function automatic logic [7:0] reg_offset(input int layout, input int idx);
    logic [7:0] off;
    case (idx)
      IDX_STAT: off = (layout == 0) ? 8'h28 : 8'h18;
      IDX_IEN:  off = (layout == 0) ? 8'h2C : 8'h1C;
      IDX_CTRL: off = (layout == 0) ? 8'h38 : 8'h24;
      IDX_CNT:  off = (layout == 0) ? 8'h3C : 8'h28;
      default:  off = (layout == 0) ? 8'h40 : 8'h2C;
    endcase
    return off;
  endfunction

  // Next counter value for one tick: wrap takes the reload value
  function automatic logic [DATA_W-1:0] advance(input logic [DATA_W-1:0] cur,
                                                input logic [DATA_W-1:0] ld);
    return (&cur) ? ld : cur + 1'b1;
  endfunction
endpackage

// File: rtl/ovt_decode.sv
module ovt_decode
  import ovt_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int LAYOUT = 0
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [NREG-1:0]   hit
);
  for (genvar i = 0; i < NREG; i++) begin : g_hit
    assign hit[i] = (addr == ADDR_W'(reg_offset(LAYOUT, i)));
  end

  always_comb begin
    a_r2_single_hit: assert ($onehot0(hit));
  end
endmodule

// File: rtl/ovt_counter.sv
module ovt_counter
  import ovt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              tick_en,
  input  logic              cnt_we,
  input  logic [DATA_W-1:0] wdata,
  input  logic [DATA_W-1:0] load,
  output logic [DATA_W-1:0] cnt_q,
  output logic              ovf_evt
);
  logic step;
  logic at_max;

  always_comb begin
    step    = run & tick_en;
    at_max  = &cnt_q;
    ovf_evt = step & at_max & ~cnt_we;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_we) cnt_q <= wdata;
    else if (step)   cnt_q <= advance(cnt_q, load);
  end

  a_r3_increment: assert property (@(posedge clk) disable iff (!rst_n)
    step && !cnt_we && !at_max |=> cnt_q == DATA_W'($past(cnt_q) + 1'b1));
  a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !step && !cnt_we |=> $stable(cnt_q));
  a_r4_preset_wins: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_we && step |=> cnt_q == $past(wdata));
  a_r5_reload: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_evt |=> cnt_q == $past(load));
endmodule

// File: rtl/ovt_intc.sv
module ovt_intc
  import ovt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ovf_evt,
  input  logic              clr_ovf,
  input  logic              ien_we,
  input  logic [IEN_W-1:0]  ien_wdata,
  output logic [DATA_W-1:0] stat,
  output logic [DATA_W-1:0] ien,
  output logic              irq
);
  logic             ovf_q;
  logic [IEN_W-1:0] ien_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ovf_q <= 1'b0;
    else if (ovf_evt) ovf_q <= 1'b1;
    else if (clr_ovf) ovf_q <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ien_q <= '0;
    else if (ien_we) ien_q <= ien_wdata;
  end

  always_comb begin
    stat = DATA_W'(ovf_q) << OVF_BIT;
    ien  = DATA_W'(ien_q);
    irq  = |(stat & ien);
  end

  a_r6_set: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_evt |=> stat[OVF_BIT]);
  a_r6_clear: assert property (@(posedge clk) disable iff (!rst_n)
    clr_ovf && !ovf_evt |=> !stat[OVF_BIT]);
  a_r9_masked: assert property (@(posedge clk) disable iff (!rst_n)
    !ien[OVF_BIT] |-> !irq);
  a_r9_level: assert property (@(posedge clk) disable iff (!rst_n)
    stat[OVF_BIT] && ien[OVF_BIT] |-> irq);
endmodule

// File: rtl/ovf_timer.sv
module ovf_timer
  import ovt_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int LAYOUT = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq
);
  logic [NREG-1:0]   hit;
  logic [NREG-1:0]   we;
  logic [CTRL_W-1:0] ctrl_q;
  logic [DATA_W-1:0] load_q;
  logic [DATA_W-1:0] cnt_q;
  logic [DATA_W-1:0] stat;
  logic [DATA_W-1:0] ien;
  logic              ovf_evt;
  logic              clr_ovf;

  ovt_decode #(.ADDR_W(ADDR_W), .LAYOUT(LAYOUT)) u_dec (
    .addr(bus_addr), .hit(hit)
  );

  assign we      = hit & {NREG{bus_wr}};
  assign clr_ovf = we[IDX_STAT] & bus_wdata[OVF_BIT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             load_q <= '0;
    else if (we[IDX_LOAD])  load_q <= bus_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          ctrl_q <= '0;
    else if (we[IDX_CTRL])               ctrl_q <= bus_wdata[CTRL_W-1:0];
    else if (ovf_evt && !ctrl_q[AUTO_BIT]) ctrl_q[START_BIT] <= 1'b0;
  end

  ovt_counter u_cnt (
    .clk(clk), .rst_n(rst_n), .run(ctrl_q[START_BIT]), .tick_en(tick_en),
    .cnt_we(we[IDX_CNT]), .wdata(bus_wdata), .load(load_q),
    .cnt_q(cnt_q), .ovf_evt(ovf_evt)
  );

  ovt_intc u_irq (
    .clk(clk), .rst_n(rst_n), .ovf_evt(ovf_evt), .clr_ovf(clr_ovf),
    .ien_we(we[IDX_IEN]), .ien_wdata(bus_wdata[IEN_W-1:0]),
    .stat(stat), .ien(ien), .irq(irq)
  );

  always_comb begin
    bus_rdata = '0;
    if (hit[IDX_STAT])      bus_rdata = stat;
    else if (hit[IDX_IEN])  bus_rdata = ien;
    else if (hit[IDX_CTRL]) bus_rdata = DATA_W'(ctrl_q);
    else if (hit[IDX_CNT])  bus_rdata = cnt_q;
    else if (hit[IDX_LOAD]) bus_rdata = load_q;
  end

  a_r7_oneshot_stop: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_evt && !ctrl_q[AUTO_BIT] && !we[IDX_CTRL] |=> !ctrl_q[START_BIT]);
  a_r5_autoreload_runs: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_evt && ctrl_q[AUTO_BIT] && !we[IDX_CTRL] |=> ctrl_q[START_BIT]);
endmodule

// File: tb/ovf_timer_test.sv
`timescale 1ns/1ps
module ovf_timer_test;
  localparam logic [7:0] A_STAT = 8'h28, A_IEN = 8'h2C, A_CTRL = 8'h38,
                         A_CNT = 8'h3C, A_LOAD = 8'h40;
  localparam logic [7:0] B_STAT = 8'h18, B_IEN = 8'h1C, B_CTRL = 8'h24,
                         B_CNT = 8'h28, B_LOAD = 8'h2C;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_en = 1'b0;
  logic [7:0]  addr_a = '0, addr_b = '0;
  logic        wr_a = 1'b0, wr_b = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata_a, rdata_b;
  logic        irq_a, irq_b;
  int          checks = 0;
  int          errors = 0;
  bit          done = 1'b0;

  always #2 clk = ~clk;

  ovf_timer #(.ADDR_W(8), .LAYOUT(0)) uut (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .bus_addr(addr_a),
    .bus_wr(wr_a), .bus_wdata(wdata), .bus_rdata(rdata_a), .irq(irq_a));
  ovf_timer #(.ADDR_W(8), .LAYOUT(1)) uut_b (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .bus_addr(addr_b),
    .bus_wr(wr_b), .bus_wdata(wdata), .bus_rdata(rdata_b), .irq(irq_b));

  function automatic logic [31:0] period_load(input int n);
    return 32'hFFFF_FFFF - 32'(n - 1);
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input bit b, input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    wdata = d;
    if (b) begin addr_b = a; wr_b = 1'b1; end
    else   begin addr_a = a; wr_a = 1'b1; end
    @(negedge clk);
    wr_a = 1'b0; wr_b = 1'b0;
  endtask

  task automatic rd(input bit b, input logic [7:0] a, output logic [31:0] d);
    if (b) addr_b = a; else addr_a = a;
    #0.01;
    d = b ? rdata_b : rdata_a;
  endtask

  task automatic ticks(input int n);
    @(negedge clk);
    tick_en = 1'b1;
    repeat (n) @(negedge clk);
    tick_en = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] v, r, ld;
    void'($urandom(32'd7741));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(0, A_STAT, v); chk("R1 status", v, 0);
    rd(0, A_IEN, v);  chk("R1 enable", v, 0);
    rd(0, A_CTRL, v); chk("R1 control", v, 0);
    rd(0, A_CNT, v);  chk("R1 counter", v, 0);
    rd(0, A_LOAD, v); chk("R1 reload", v, 0);
    chk("R1 irq", {31'b0, irq_a}, 0);

    // R2 register placement, random readback, unmapped offsets
    for (int i = 0; i < 6; i++) begin
      r = $urandom();
      wr(0, A_LOAD, r); rd(0, A_LOAD, v); chk("R2 reload readback A", v, r);
      r = $urandom();
      wr(1, B_LOAD, r); rd(1, B_LOAD, v); chk("R2 reload readback B", v, r);
      r = $urandom();
      wr(1, B_CNT, r);  rd(1, B_CNT, v);  chk("R2 counter readback B", v, r);
    end
    rd(0, 8'h18, v); chk("R2 A unmapped 0x18", v, 0);
    rd(0, 8'h00, v); chk("R2 A unmapped 0x00", v, 0);
    rd(1, 8'h3C, v); chk("R2 B unmapped 0x3C", v, 0);
    rd(1, 8'h40, v); chk("R2 B unmapped 0x40", v, 0);
    wr(0, 8'h30, 32'hFFFF_FFFF);
    rd(0, A_CTRL, v); chk("R2 unmapped write ignored", v, 0);

    // R8 field widths
    wr(0, A_IEN, 32'hFFFF_FFFF);  rd(0, A_IEN, v);  chk("R8 enable bits", v, 32'h7);
    wr(0, A_CTRL, 32'hFFFF_FFFC); rd(0, A_CTRL, v); chk("R8 control bits", v, 0);
    wr(0, A_STAT, 32'hFFFF_FFFF); rd(0, A_STAT, v); chk("R8 status reads zero", v, 0);
    wr(1, B_IEN, 32'h0000_0005);  rd(1, B_IEN, v);  chk("R8 enable B", v, 32'h5);

    // R3 no counting while stopped
    wr(0, A_CNT, 32'h1234);
    ticks(7);
    rd(0, A_CNT, v); chk("R3 hold when stopped", v, 32'h1234);

    // R10 / R3 free-running counts with random presets
    wr(0, A_LOAD, 0);
    wr(0, A_CTRL, 32'h3);
    for (int i = 0; i < 5; i++) begin
      int k;
      r = $urandom() & 32'h7FFF_FFFF;
      k = 1 + ($urandom() % 50);
      wr(0, A_CNT, r);
      ticks(k);
      rd(0, A_CNT, v); chk("R10 free run count", v, r + 32'(k));
    end

    // R4 counter write beats increment
    @(negedge clk); tick_en = 1'b1;
    wr(0, A_CNT, 32'hCAFE_0000);
    tick_en = 1'b0;
    rd(0, A_CNT, v); chk("R4 write priority", v, 32'hCAFE_0000);

    // R5 / R6 / R9 periodic overflow with random period
    wr(0, A_IEN, 32'h2);
    for (int i = 0; i < 3; i++) begin
      int n;
      n = 3 + ($urandom() % 30);
      ld = period_load(n);
      wr(0, A_LOAD, ld);
      wr(0, A_CNT, ld);
      wr(0, A_STAT, 32'h2);
      ticks(n - 1);
      rd(0, A_STAT, v); chk("R5 no flag before period", v, 0);
      rd(0, A_CNT, v);  chk("R5 count at top", v, 32'hFFFF_FFFF);
      ticks(1);
      rd(0, A_STAT, v); chk("R6 flag at period", v, 32'h2);
      rd(0, A_CNT, v);  chk("R5 reloaded", v, ld);
      chk("R9 irq raised", {31'b0, irq_a}, 1);
      wr(0, A_STAT, 32'h0);
      rd(0, A_STAT, v); chk("R6 write zero keeps flag", v, 32'h2);
      wr(0, A_STAT, 32'h2);
      rd(0, A_STAT, v); chk("R6 clear by one", v, 0);
      chk("R9 irq dropped", {31'b0, irq_a}, 0);
      ticks(n);
      rd(0, A_STAT, v); chk("R5 second period flag", v, 32'h2);
      rd(0, A_CTRL, v); chk("R5 still running", v, 32'h3);
    end

    // R9 masking: match and capture enables do not pass the overflow flag
    wr(0, A_IEN, 32'h5);
    chk("R9 masked irq", {31'b0, irq_a}, 0);
    wr(0, A_IEN, 32'h2);
    chk("R9 enabled irq", {31'b0, irq_a}, 1);

    // R6 overflow in the same cycle as a clear keeps the flag
    wr(0, A_LOAD, 32'h55);
    wr(0, A_CNT, 32'hFFFF_FFFF);
    @(negedge clk);
    tick_en = 1'b1; wdata = 32'h2; addr_a = A_STAT; wr_a = 1'b1;
    @(negedge clk);
    tick_en = 1'b0; wr_a = 1'b0;
    rd(0, A_STAT, v); chk("R6 set beats clear", v, 32'h2);
    rd(0, A_CNT, v);  chk("R6 reload on collision", v, 32'h55);
    wr(0, A_STAT, 32'h2);

    // R7 one-shot
    wr(0, A_LOAD, 32'h100);
    wr(0, A_CNT, 32'hFFFF_FFFE);
    wr(0, A_CTRL, 32'h1);
    ticks(2);
    rd(0, A_CNT, v);  chk("R7 one-shot reload", v, 32'h100);
    rd(0, A_STAT, v); chk("R7 one-shot flag", v, 32'h2);
    rd(0, A_CTRL, v); chk("R7 start cleared", v, 0);
    chk("R7 irq", {31'b0, irq_a}, 1);
    ticks(5);
    rd(0, A_CNT, v);  chk("R7 holds after stop", v, 32'h100);

    // R2 / R5 layout B runs independently
    wr(1, B_LOAD, period_load(4));
    wr(1, B_CNT, period_load(4));
    wr(1, B_IEN, 32'h2);
    wr(1, B_CTRL, 32'h3);
    ticks(4);
    rd(1, B_STAT, v); chk("R2 layout B status", v, 32'h2);
    chk("R9 layout B irq", {31'b0, irq_b}, 1);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule